// File: doc/BRIEF.md
# Two-Byte Accumulator Processor Core

This block is a small 8-bit processor built around a single accumulator. Every instruction occupies two consecutive bytes in a 256-byte memory: an opcode byte, then an operand byte. The core walks through a multi-cycle sequence for each instruction. It fetches the opcode, fetches the operand, makes an optional value read, executes, and makes an optional write. All of its memory traffic goes over one byte-wide request/acknowledge port.

There is no branch-to-target form of conditional control. A comparison or flag test can only skip the single instruction that follows. Four status flags can be flipped one at a time by number, and any one of them can drive a skip. A halt instruction stops the core until reset. A debug view exposes the accumulator, the instruction pointer and the flags so that a harness can observe progress.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, the accumulator, instruction pointer and all four flags read zero and the halted output is low. Once the core is running, its first request is an opcode read at address 0x00.
- R2: The opcode is read at IP and the operand at IP+1. Load, add, subtract, store, flag toggle, no-op and halt advance IP by 2. All IP arithmetic wraps modulo 256.
- R3: Store writes the accumulator to memory and leaves the flags unchanged. Opcode 0x01 writes to address `operand`. Opcode 0x02 first reads `mem[operand]` and then writes to the address held there.
- R4: Load sets A to the operand (0x03) or to `mem[operand]` (0x04). It updates N and Z and keeps O and C.
- R5: Add sets A to A plus the value. The value is the operand for 0x05 and `mem[operand]` for 0x06. C is the carry out of bit 7, O is signed overflow, and N and Z follow the result.
- R6: Subtract computes A + ~value + 1. The value is the operand for 0x07 and `mem[operand]` for 0x08. C is set when no borrow occurs, O is signed overflow, and N and Z follow the result.
- R7: The compare-skip instruction adds 4 to IP when A equals the value and adds 2 otherwise. The value is the operand for 0x09 and `mem[operand]` for 0x0A. Flags are unchanged.
- R8: Jump loads IP with the operand (0x0B) or with `mem[operand]` (0x0C).
- R9: Opcode 0x0D inverts the flag numbered by the operand. Flag 0 is C, 1 is O, 2 is Z and 3 is N, and these numbers are also the bit positions on the flag debug output. An operand above 3 changes nothing and advances IP by 2.
- R10: Opcode 0x0E adds 4 to IP when the flag numbered by the operand is set and adds 2 otherwise. An operand above 3 never skips.
- R11: Opcode 0x00 raises halted and leaves IP at the halt address plus 2. After that the core issues no memory request and its state stays still until reset. Opcode 0x0F and every opcode above 0x0F act as no-ops.
- R12: A request holds its address and direction steady until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 8 | Byte address |
| mem_wdata | output | 8 | Write data (accumulator) |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 8 | Read data |
| halted | output | 1 | Core has executed a halt |
| dbg_acc | output | 8 | Accumulator |
| dbg_ip | output | 8 | Instruction pointer |
| dbg_flags | output | 4 | Flags, bit 0 C, bit 1 O, bit 2 Z, bit 3 N |

## Verification
Two functions can act in the same execute cycle: a taken skip adding 4 to IP and the modulo-256 wrap of IP. A second collision is a flag toggle next to a flag-driven skip on that same flag. The first is provoked by jumping to 0xFC, loading zero and placing a taken compare-skip at 0xFE. The fetch must land on 0x02, and a halt placed there must leave IP at 0x04. The second is provoked with a toggle-then-skip sequence in which a skipped load would otherwise clear N. The final flags and IP show whether the skip saw the toggled value.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int unsigned DW    = 8;
    localparam int unsigned NFLAG = 4;

    localparam int unsigned FLAG_C = 0;
    localparam int unsigned FLAG_O = 1;
    localparam int unsigned FLAG_Z = 2;
    localparam int unsigned FLAG_N = 3;

    typedef enum logic [2:0] {
        ST_FOP,
        ST_FARG,
        ST_RDV,
        ST_EXEC,
        ST_WR,
        ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        K_END,
        K_STO,
        K_LDA,
        K_ADD,
        K_SUB,
        K_HOP,
        K_JMP,
        K_FTG,
        K_FHP,
        K_NOP
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  indirect;
    } dec_t;

    typedef struct packed {
        state_e            st;
        logic [DW-1:0]     acc;
        logic [DW-1:0]     ip;
        logic [DW-1:0]     op;
        logic [DW-1:0]     arg;
        logic [DW-1:0]     val;
        logic [NFLAG-1:0]  flg;
    } core_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
#(
    parameter int unsigned W = acc_pkg::DW
) (
    input  logic [W-1:0] opcode,
    output dec_t         dec
);
    localparam int unsigned LOW_W = 4;

    logic upper_zero;

    always_comb begin
        upper_zero   = (opcode[W-1:LOW_W] == '0);
        dec.kind     = K_NOP;
        dec.indirect = 1'b0;
        if (upper_zero) begin
            case (opcode[LOW_W-1:0])
                4'h0: dec.kind = K_END;
                4'h1: dec.kind = K_STO;
                4'h2: begin dec.kind = K_STO; dec.indirect = 1'b1; end
                4'h3: dec.kind = K_LDA;
                4'h4: begin dec.kind = K_LDA; dec.indirect = 1'b1; end
                4'h5: dec.kind = K_ADD;
                4'h6: begin dec.kind = K_ADD; dec.indirect = 1'b1; end
                4'h7: dec.kind = K_SUB;
                4'h8: begin dec.kind = K_SUB; dec.indirect = 1'b1; end
                4'h9: dec.kind = K_HOP;
                4'hA: begin dec.kind = K_HOP; dec.indirect = 1'b1; end
                4'hB: dec.kind = K_JMP;
                4'hC: begin dec.kind = K_JMP; dec.indirect = 1'b1; end
                4'hD: dec.kind = K_FTG;
                4'hE: dec.kind = K_FHP;
                default: dec.kind = K_NOP;
            endcase
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int unsigned W = acc_pkg::DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         fl_n,
    output logic         fl_z,
    output logic         fl_o,
    output logic         fl_c
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        res   = sum[W-1:0];
        fl_c  = sum[W];
        fl_o  = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
        fl_n  = res[W-1];
        fl_z  = (res == '0);
    end

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit #(
    parameter int unsigned W  = acc_pkg::DW,
    parameter int unsigned NF = acc_pkg::NFLAG
) (
    input  logic [NF-1:0] flg,
    input  logic [W-1:0]  idx,
    output logic [NF-1:0] flg_toggled,
    output logic          flg_sel
);
    logic [NF-1:0] hit;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        assign hit[i]         = (idx == W'(i));
        assign flg_toggled[i] = flg[i] ^ hit[i];
    end

    assign flg_sel = |(flg & hit);

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             halted,
    output logic [DW-1:0]    dbg_acc,
    output logic [DW-1:0]    dbg_ip,
    output logic [NFLAG-1:0] dbg_flags
);
    localparam logic [DW-1:0] STEP_ONE  = DW'(1);
    localparam logic [DW-1:0] STEP_INSN = DW'(2);
    localparam logic [DW-1:0] STEP_SKIP = DW'(4);

    core_t r_q, r_d;
    dec_t  dec;

    logic [DW-1:0]    operand;
    logic [DW-1:0]    alu_res;
    logic             alu_n, alu_z, alu_o, alu_c;
    logic [NFLAG-1:0] flg_tog;
    logic             flg_sel;

    acc_decode #(.W(DW)) u_decode (
        .opcode (r_q.op),
        .dec    (dec)
    );

    assign operand = dec.indirect ? r_q.val : r_q.arg;

    acc_alu #(.W(DW)) u_alu (
        .a    (r_q.acc),
        .b    (operand),
        .sub  (dec.kind == K_SUB),
        .res  (alu_res),
        .fl_n (alu_n),
        .fl_z (alu_z),
        .fl_o (alu_o),
        .fl_c (alu_c)
    );

    acc_flag_unit #(.W(DW), .NF(NFLAG)) u_flags (
        .flg         (r_q.flg),
        .idx         (r_q.arg),
        .flg_toggled (flg_tog),
        .flg_sel     (flg_sel)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.ip;
        mem_wdata = r_q.acc;

        case (r_q.st)
            ST_FOP: begin
                mem_req  = 1'b1;
                mem_addr = r_q.ip;
                if (mem_ack) begin
                    r_d.op = mem_rdata;
                    r_d.st = ST_FARG;
                end
            end
            ST_FARG: begin
                mem_req  = 1'b1;
                mem_addr = r_q.ip + STEP_ONE;
                if (mem_ack) begin
                    r_d.arg = mem_rdata;
                    if (dec.indirect)
                        r_d.st = ST_RDV;
                    else if (dec.kind == K_STO)
                        r_d.st = ST_WR;
                    else
                        r_d.st = ST_EXEC;
                end
            end
            ST_RDV: begin
                mem_req  = 1'b1;
                mem_addr = r_q.arg;
                if (mem_ack) begin
                    r_d.val = mem_rdata;
                    r_d.st  = (dec.kind == K_STO) ? ST_WR : ST_EXEC;
                end
            end
            ST_EXEC: begin
                r_d.st = ST_FOP;
                r_d.ip = r_q.ip + STEP_INSN;
                case (dec.kind)
                    K_END: r_d.st = ST_HALT;
                    K_LDA: begin
                        r_d.acc         = operand;
                        r_d.flg[FLAG_N] = operand[DW-1];
                        r_d.flg[FLAG_Z] = (operand == '0);
                    end
                    K_ADD, K_SUB: begin
                        r_d.acc         = alu_res;
                        r_d.flg[FLAG_N] = alu_n;
                        r_d.flg[FLAG_Z] = alu_z;
                        r_d.flg[FLAG_O] = alu_o;
                        r_d.flg[FLAG_C] = alu_c;
                    end
                    K_HOP: begin
                        if (r_q.acc == operand)
                            r_d.ip = r_q.ip + STEP_SKIP;
                    end
                    K_JMP: r_d.ip = operand;
                    K_FTG: r_d.flg = flg_tog;
                    K_FHP: begin
                        if (flg_sel)
                            r_d.ip = r_q.ip + STEP_SKIP;
                    end
                    default: ;
                endcase
            end
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dec.indirect ? r_q.val : r_q.arg;
                if (mem_ack) begin
                    r_d.ip = r_q.ip + STEP_INSN;
                    r_d.st = ST_FOP;
                end
            end
            ST_HALT: ;
            default: r_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_FOP;
            r_q.acc <= '0;
            r_q.ip  <= '0;
            r_q.op  <= '0;
            r_q.arg <= '0;
            r_q.val <= '0;
            r_q.flg <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign halted    = (r_q.st == ST_HALT);
    assign dbg_acc   = r_q.acc;
    assign dbg_ip    = r_q.ip;
    assign dbg_flags = r_q.flg;

    // R11: a halted core stays silent on the memory port
    assert_halt_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R11: halt is only left through reset
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(dbg_ip) && $stable(dbg_acc)));

    // R12: unacknowledged request keeps its address and direction
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: plain data instructions step IP by one instruction
    assert_ip_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EXEC && (dec.kind == K_LDA || dec.kind == K_ADD ||
                               dec.kind == K_SUB || dec.kind == K_NOP))
        |=> (dbg_ip == $past(dbg_ip) + STEP_INSN));

    // R4: load leaves overflow and carry as they were
    assert_lda_keeps_oc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EXEC && dec.kind == K_LDA)
        |=> (dbg_flags[FLAG_O] == $past(dbg_flags[FLAG_O]) &&
             dbg_flags[FLAG_C] == $past(dbg_flags[FLAG_C])));

    // R3: a store write cycle never disturbs the flags
    assert_sto_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> $stable(dbg_flags));

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_req, mem_we, mem_ack, halted;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, dbg_acc, dbg_ip;
    logic [3:0] dbg_flags;

    logic [7:0] mem [256];
    int vectors = 0;
    int misses  = 0;
    int hs_err  = 0;
    logic       prev_pend = 1'b0;
    logic [7:0] prev_addr = '0;

    always #10 clk = ~clk;

    acc_core u_acc_core (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .halted(halted), .dbg_acc(dbg_acc), .dbg_ip(dbg_ip), .dbg_flags(dbg_flags)
    );

    // one-cycle memory responder
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // R12 handshake monitor
    always @(negedge clk) begin
        if (rst_n && prev_pend && (!mem_req || mem_addr != prev_addr)) hs_err++;
        prev_pend = rst_n && mem_req && !mem_ack;
        prev_addr = mem_addr;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_clear();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1);
        mem[a]        = d0;
        mem[a + 8'd1] = d1;
    endtask

    task automatic run_prog(input string req);
        int n;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, halted, 1'b1);
    endtask

    task automatic t_reset();
        load_clear();
        @(negedge clk);
        chk("R1 acc", dbg_acc, 0);
        chk("R1 ip", dbg_ip, 0);
        chk("R1 flags", dbg_flags, 0);
        chk("R1 halted", halted, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first req", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 8'h00});
    endtask

    task automatic t_load_store();
        load_clear();
        poke(8'h00, 8'h03, 8'h80);
        poke(8'h02, 8'h01, 8'h40);
        poke(8'h04, 8'h02, 8'h42);
        poke(8'h06, 8'h04, 8'h41);
        poke(8'h08, 8'h00, 8'h00);
        mem[8'h42] = 8'h50;
        run_prog("R11 halt ls");
        chk("R3 direct store", mem[8'h40], 8'h80);
        chk("R3 indirect store", mem[8'h50], 8'h80);
        chk("R4 load addr", dbg_acc, 8'h00);
        chk("R4 NZ flags", dbg_flags, 4'b0100);
        chk("R2 R11 ip after halt", dbg_ip, 8'h0A);
    endtask

    task automatic t_arith(input string req, input logic [7:0] a0, input logic [7:0] opc,
                           input logic [7:0] b, input logic [7:0] exp_a, input logic [3:0] exp_f);
        load_clear();
        poke(8'h00, 8'h03, a0);
        poke(8'h02, opc, (opc[0]) ? b : 8'h30);
        poke(8'h04, 8'h00, 8'h00);
        mem[8'h30] = b;
        run_prog(req);
        chk(req, dbg_acc, exp_a);
        chk(req, dbg_flags, exp_f);
        chk("R2 ip", dbg_ip, 8'h06);
    endtask

    task automatic t_lda_keeps();
        load_clear();
        poke(8'h00, 8'h03, 8'h7F);
        poke(8'h02, 8'h05, 8'h01);
        poke(8'h04, 8'h03, 8'h01);
        poke(8'h06, 8'h00, 8'h00);
        run_prog("R4 run");
        chk("R4 acc", dbg_acc, 8'h01);
        chk("R4 keeps O", dbg_flags, 4'b0010);
    endtask

    task automatic t_hop();
        load_clear();
        poke(8'h00, 8'h03, 8'h05);
        poke(8'h02, 8'h09, 8'h05);
        poke(8'h04, 8'h03, 8'h99);
        poke(8'h06, 8'h0A, 8'h30);
        poke(8'h08, 8'h05, 8'h01);
        poke(8'h0A, 8'h0A, 8'h31);
        poke(8'h0C, 8'h03, 8'hEE);
        poke(8'h0E, 8'h00, 8'h00);
        mem[8'h30] = 8'h06;
        mem[8'h31] = 8'h06;
        run_prog("R7 run");
        chk("R7 skip paths", dbg_acc, 8'h06);
        chk("R7 ip", dbg_ip, 8'h10);
        chk("R7 flags", dbg_flags, 4'b0000);
    endtask

    task automatic t_jmp();
        load_clear();
        poke(8'h00, 8'h0B, 8'h10);
        poke(8'h02, 8'h03, 8'hAA);
        poke(8'h04, 8'h00, 8'h00);
        poke(8'h10, 8'h0C, 8'h30);
        poke(8'h12, 8'h03, 8'hBB);
        poke(8'h20, 8'h03, 8'h42);
        poke(8'h22, 8'h00, 8'h00);
        mem[8'h30] = 8'h20;
        run_prog("R8 run");
        chk("R8 acc", dbg_acc, 8'h42);
        chk("R8 ip", dbg_ip, 8'h24);
    endtask

    task automatic t_flags();
        load_clear();
        poke(8'h00, 8'h0D, 8'h00);
        poke(8'h02, 8'h0D, 8'h03);
        poke(8'h04, 8'h0D, 8'h07);
        poke(8'h06, 8'h0E, 8'h00);
        poke(8'h08, 8'h03, 8'h01);
        poke(8'h0A, 8'h0E, 8'h02);
        poke(8'h0C, 8'h0D, 8'h01);
        poke(8'h0E, 8'h0E, 8'h09);
        poke(8'h10, 8'h0D, 8'h02);
        poke(8'h12, 8'h0D, 8'h00);
        poke(8'h14, 8'h00, 8'h00);
        run_prog("R9 run");
        chk("R9 R10 flags", dbg_flags, 4'b1110);
        chk("R10 skipped load", dbg_acc, 8'h00);
        chk("R10 ip", dbg_ip, 8'h16);
    endtask

    task automatic t_nop();
        load_clear();
        poke(8'h00, 8'h0F, 8'h55);
        poke(8'h02, 8'h3C, 8'h01);
        poke(8'h04, 8'h03, 8'h21);
        poke(8'h06, 8'h00, 8'h00);
        run_prog("R11 nop run");
        chk("R11 nop acc", dbg_acc, 8'h21);
        chk("R11 nop flags", dbg_flags, 4'b0000);
        chk("R11 nop ip", dbg_ip, 8'h08);
    endtask

    task automatic t_wrap();
        load_clear();
        poke(8'h00, 8'h0B, 8'hFC);
        poke(8'h02, 8'h00, 8'h00);
        poke(8'hFC, 8'h03, 8'h00);
        poke(8'hFE, 8'h09, 8'h00);
        run_prog("R2 wrap run");
        chk("R2 R7 wrap ip", dbg_ip, 8'h04);
        chk("R2 wrap flags", dbg_flags, 4'b0100);
    endtask

    task automatic t_halt_quiet();
        int reqs;
        logic [7:0] ip0;
        reqs = 0;
        ip0  = dbg_ip;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk("R11 no req when halted", reqs, 0);
        chk("R11 ip frozen", dbg_ip, ip0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        t_reset();
        t_load_store();
        t_halt_quiet();
        t_arith("R5 add ovf", 8'h7F, 8'h05, 8'h01, 8'h80, 4'b1010);
        t_arith("R5 add carry", 8'hFF, 8'h06, 8'h01, 8'h00, 4'b0101);
        t_arith("R6 sub equal", 8'h05, 8'h07, 8'h05, 8'h00, 4'b0101);
        t_arith("R6 sub ovf", 8'h80, 8'h08, 8'h01, 8'h7F, 4'b0011);
        t_arith("R6 sub borrow", 8'h03, 8'h07, 8'h05, 8'hFE, 4'b1000);
        t_lda_keeps();
        t_hop();
        t_jmp();
        t_flags();
        t_nop();
        t_wrap();
        t_halt_quiet();
        chk("R12 handshake", hs_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule